// File: doc/BRIEF.md
# Channel-Interleaved Sample Transposer

The block turns a channel-serial capture stream into parallel logic samples. Bytes arrive in pairs, and each pair forms one 16-bit word. That word holds sixteen consecutive time samples of a single channel. Words arrive in a fixed rotation that visits each enabled channel once, from the lowest channel to the highest, and then starts again. The block builds these words into sixteen parallel samples. Each sample has one bit per channel. When the word for the last enabled channel of a round has arrived, the block sends the sixteen samples out in time order.

A `start` pulse begins a capture. It latches the channel-enable mask and clears any partly built round. While the finished samples drain, input is held off through `in_ready`. The output side uses a valid/ready handshake. A transfer boundary is marked with `in_last`. If a transfer closes on an unpaired byte, that byte is dropped and a one-cycle error pulse is raised.

Top module: `sample_transposer`

## Requirements
- R1: A word is formed from two accepted bytes: the first byte is bits 7:0 and the second byte is bits 15:8.
- R2: Word bit 15 is the earliest sample and goes to the first output sample of the round. Word bit 0 goes to the sixteenth output sample.
- R3: Words are assigned to the enabled channels in ascending channel order and wrap after the highest one. Bit c of an output sample carries channel c. Exactly 16 samples are emitted per round, and the first becomes valid in the cycle after the last enabled channel's word is accepted.
- R4: Output bit positions of channels not enabled in the latched mask are always zero.
- R5: The accumulated samples are cleared after the sixteenth output handshake, so consecutive rounds do not mix.
- R6: `in_ready` is low before the first `start` and during the whole output drain.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` is unchanged.
- R8: When a byte with `in_last` is accepted as the first byte of a pair (odd transfer length), `odd_err` is high for exactly the following cycle. That byte is discarded, and the next byte starts a new pair. A transfer of even length gives no pulse.
- R9: `chan_en` is sampled only on `start`. Later changes have no effect until the next `start`. A `start` also discards a partially built round.
- R10: With an all-zero latched mask, bytes are still accepted but no output sample is ever produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin capture: latch mask, clear partial state |
| chan_en | input | 16 | Channel-enable mask, bit c enables channel c |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_last | input | 1 | Byte closes the current transfer |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 16 | Parallel sample, bit c is channel c |
| out_ready | input | 1 | Consumer accepts the sample |
| odd_err | output | 1 | One-cycle pulse: transfer ended on an unpaired byte |

## Verification
The bench uses word patterns that expose a swapped byte order or a reversed time order. Either fault would put ones in the wrong half of the sixteen samples. Sparse and single-channel masks test the rotation and wrap: a design that counted channels rather than skipping disabled ones would close the round early or late, or put bits in unused positions. The bench also covers these cases:
- An odd-length transfer followed by a full word. A design that kept the stray byte would shift every later word by one byte.
- A mask change in the middle of a capture.
- A restart part-way through a round. This catches designs that resample the mask or keep stale accumulator bits.
- A stalled consumer. This catches output that advances, or input that is accepted, during the drain.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} byte_phase_e;
endpackage

// File: rtl/xpose_byte_pair.sv
module xpose_byte_pair #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last,
  output logic              word_fire,
  output logic [WORD_W-1:0] word,
  output logic              odd_pulse
);
  import xpose_pkg::*;

  byte_phase_e       phase;
  logic [BYTE_W-1:0] low_q;

  assign word      = {byte_in, low_q};
  assign word_fire = take && (phase == PH_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_LOW;
      low_q     <= '0;
      odd_pulse <= 1'b0;
    end else begin
      odd_pulse <= 1'b0;
      if (clear) begin
        phase <= PH_LOW;
      end else if (take) begin
        if (phase == PH_LOW) begin
          if (last) begin
            odd_pulse <= 1'b1;      // stray byte dropped, pairing restarts
          end else begin
            low_q <= byte_in;
            phase <= PH_HIGH;
          end
        end else begin
          phase <= PH_LOW;
        end
      end
    end
  end
endmodule

// File: rtl/xpose_chan_seq.sv
module xpose_chan_seq #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCH-1:0] mask_in,
  input  logic           advance,
  output logic [NCH-1:0] mask_q,
  output logic [CW-1:0]  cur_ch,
  output logic           frame_end,
  output logic           running
);
  function automatic logic [CW-1:0] lowest_en(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = i[CW-1:0];
    return r;
  endfunction

  function automatic logic [CW-1:0] highest_en(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++)
      if (m[i]) r = i[CW-1:0];
    return r;
  endfunction

  function automatic logic [CW-1:0] after_en(input logic [NCH-1:0] m,
                                             input logic [CW-1:0]  c);
    logic [CW-1:0] r;
    logic          hit;
    r   = lowest_en(m);
    hit = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (!hit && m[i] && (i > int'(c))) begin
        r   = i[CW-1:0];
        hit = 1'b1;
      end
    return r;
  endfunction

  assign frame_end = (|mask_q) && (cur_ch == highest_en(mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cur_ch  <= '0;
      running <= 1'b0;
    end else if (start) begin
      mask_q  <= mask_in;
      cur_ch  <= lowest_en(mask_in);
      running <= 1'b1;
    end else if (advance && (|mask_q)) begin
      cur_ch <= after_en(mask_q, cur_ch);
    end
  end
endmodule

// File: rtl/xpose_accum.sv
module xpose_accum #(
  parameter int NCH  = 16,
  parameter int SAMP = 16,
  localparam int CW = $clog2(NCH),
  localparam int IW = $clog2(SAMP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            load,
  input  logic [CW-1:0]   ch,
  input  logic [SAMP-1:0] word,
  input  logic            frame_end,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [NCH-1:0]  out_sample,
  output logic            draining,
  output logic            drain_done
);
  logic [NCH-1:0] acc [SAMP];
  logic [NCH-1:0] ch_bit;
  logic [IW-1:0]  idx;

  assign ch_bit     = {{(NCH-1){1'b0}}, 1'b1} << ch;
  assign out_valid  = draining;
  assign out_sample = acc[idx];
  assign drain_done = draining && out_ready && (idx == IW'(SAMP - 1));

  for (genvar k = 0; k < SAMP; k++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n || clear || drain_done)
        acc[k] <= '0;
      else if (load && word[SAMP-1-k])
        acc[k] <= acc[k] | ch_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      draining <= 1'b0;
      idx      <= '0;
    end else if (drain_done) begin
      draining <= 1'b0;
      idx      <= '0;
    end else if (draining && out_ready) begin
      idx <= idx + 1'b1;
    end else if (load && frame_end) begin
      draining <= 1'b1;
    end
  end
endmodule

// File: rtl/sample_transposer.sv
module sample_transposer #(
  parameter int NCH    = 16,
  parameter int BYTE_W = 8,
  localparam int SAMP = 2 * BYTE_W,
  localparam int CW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH-1:0]    chan_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [NCH-1:0]    out_sample,
  input  logic              out_ready,
  output logic              odd_err
);
  logic            take, word_fire, load, frame_end, running, draining, drain_done;
  logic [SAMP-1:0] word;
  logic [NCH-1:0]  mask_q;
  logic [CW-1:0]   cur_ch;

  assign in_ready = running && !draining;
  assign take     = in_valid && in_ready;
  assign load     = word_fire && (|mask_q);

  xpose_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .clear(start), .take(take), .byte_in(in_byte),
    .last(in_last), .word_fire(word_fire), .word(word), .odd_pulse(odd_err)
  );

  xpose_chan_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_in(chan_en),
    .advance(word_fire), .mask_q(mask_q), .cur_ch(cur_ch),
    .frame_end(frame_end), .running(running)
  );

  xpose_accum #(.NCH(NCH), .SAMP(SAMP)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(start), .load(load), .ch(cur_ch),
    .word(word), .frame_end(frame_end), .out_ready(out_ready),
    .out_valid(out_valid), .out_sample(out_sample), .draining(draining),
    .drain_done(drain_done)
  );
endmodule

// File: rtl/sample_transposer_chk.sv
module sample_transposer_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_last,
  input logic           out_valid,
  input logic           out_ready,
  input logic [NCH-1:0] out_sample,
  input logic           odd_err,
  input logic [NCH-1:0] mask_q,
  input logic           running
);
  // R6
  drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6
  idle_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !in_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_sample)));

  // R4
  unused_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sample & ~mask_q) == '0));

  // R8
  odd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |-> $past(in_valid && in_ready && in_last));
endmodule

bind sample_transposer sample_transposer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .in_last(in_last), .out_valid(out_valid),
  .out_ready(out_ready), .out_sample(out_sample), .odd_err(odd_err),
  .mask_q(mask_q), .running(running)
);

// File: tb/sample_transposer_tb.sv
`timescale 1ns/1ps
module sample_transposer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] chan_en = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_last = 1'b0;
  logic        in_ready, out_valid, out_ready, odd_err;
  logic [15:0] out_sample;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [15:0] words [16];

  always #2.5 clk = ~clk;

  sample_transposer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample),
    .out_ready(out_ready), .odd_err(odd_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sample(input logic [15:0] m, input int k);
    logic [15:0] e;
    e = '0;
    for (int c = 0; c < 16; c++)
      if (m[c]) e[c] = words[c][15-k];
    return e;
  endfunction

  task automatic send_byte(input logic [7:0] b, input logic l);
    int t;
    in_valid = 1'b1; in_byte = b; in_last = l;
    t = 0;
    while (!in_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input logic l);
    send_byte(w[7:0], 1'b0);
    send_byte(w[15:8], l);
  endtask

  task automatic do_start(input logic [15:0] m);
    chan_en = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R3: output must stay idle until the highest enabled channel's word is in
  task automatic fill(input logic [15:0] m, input string req);
    int hi;
    hi = -1;
    for (int c = 0; c < 16; c++) if (m[c]) hi = c;
    for (int c = 0; c < 16; c++)
      if (m[c]) begin
        if (c == hi) chk({req, " R3 idle before last word"}, out_valid, 1'b0);
        send_word(words[c], c == hi);
      end
  endtask

  task automatic collect(input logic [15:0] m, input string req);
    int t;
    out_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin
      t = 0;
      while (!out_valid && t < 50) begin @(negedge clk); t++; end
      chk({req, " out_valid"}, out_valid, 1'b1);
      chk(req, out_sample, exp_sample(m, k));
      @(negedge clk);
    end
    chk({req, " R3 exactly 16 samples"}, out_valid, 1'b0);
    chk({req, " R6 input reopened"}, in_ready, 1'b1);
  endtask

  task automatic t_reset();
    chk("R6 reset in_ready", in_ready, 1'b0);
    chk("R3 reset out_valid", out_valid, 1'b0);
    chk("R8 reset odd_err", odd_err, 1'b0);
  endtask

  task automatic t_byte_time_order();
    // R1 and R2: single channel 5, low byte = 0xFF -> samples 8..15 set
    for (int c = 0; c < 16; c++) words[c] = '0;
    words[5] = 16'h00FF;
    do_start(16'h0020);
    fill(16'h0020, "R1");
    collect(16'h0020, "R1 byte order");
    words[5] = 16'h8000;
    fill(16'h0020, "R2");
    collect(16'h0020, "R2 bit15 earliest");
  endtask

  task automatic t_all_channels();
    for (int c = 0; c < 16; c++) words[c] = 16'h1357 * (c + 1) ^ {c[3:0], 12'hA5C};
    do_start(16'hFFFF);
    fill(16'hFFFF, "R3 all");
    collect(16'hFFFF, "R3 all channels");
    // R5: second round with new data must not carry old bits
    for (int c = 0; c < 16; c++) words[c] = (c % 2 == 0) ? 16'h0F0F : 16'h0000;
    fill(16'hFFFF, "R5");
    collect(16'hFFFF, "R5 cleared between rounds");
  endtask

  task automatic t_sparse();
    for (int c = 0; c < 16; c++) words[c] = 16'hFFFF;
    do_start(16'h8421);
    fill(16'h8421, "R4");
    collect(16'h8421, "R4 sparse mask");
    words[0] = 16'h1234; words[5] = 16'hABCD; words[10] = 16'h0001; words[15] = 16'h8000;
    fill(16'h8421, "R3 wrap");
    collect(16'h8421, "R3 wrap to first");
  endtask

  task automatic t_backpressure();
    for (int c = 0; c < 16; c++) words[c] = 16'hC3A5 + c;
    do_start(16'h0003);
    out_ready = 1'b0;
    fill(16'h0003, "R7");
    for (int i = 0; i < 3; i++) begin
      chk("R7 held valid", out_valid, 1'b1);
      chk("R7 held sample", out_sample, exp_sample(16'h0003, 0));
      chk("R6 blocked in drain", in_ready, 1'b0);
      @(negedge clk);
    end
    collect(16'h0003, "R7 after stall");
  endtask

  task automatic t_odd();
    for (int c = 0; c < 16; c++) words[c] = '0;
    do_start(16'h0001);
    send_byte(8'hAB, 1'b1);
    chk("R8 odd pulse", odd_err, 1'b1);
    @(negedge clk);
    chk("R8 pulse one cycle", odd_err, 1'b0);
    words[0] = 16'h1234;
    send_byte(8'h34, 1'b0);
    send_byte(8'h12, 1'b1);
    chk("R8 even transfer no pulse", odd_err, 1'b0);
    collect(16'h0001, "R8 realigned after stray byte");
  endtask

  task automatic t_mask_latch();
    for (int c = 0; c < 16; c++) words[c] = '0;
    words[0] = 16'hF00F; words[2] = 16'h0FF0;
    do_start(16'h0005);
    send_word(words[0], 1'b0);
    chan_en = 16'hFFFF;
    send_word(words[2], 1'b1);
    chk("R9 mask change ignored", out_valid, 1'b1);
    collect(16'h0005, "R9 latched mask");
    // R9: restart discards partial round
    words[0] = 16'hFFFF;
    do_start(16'h0003);
    send_word(words[0], 1'b0);
    words[0] = 16'h0000; words[1] = 16'h5A5A;
    do_start(16'h0003);
    fill(16'h0003, "R9");
    collect(16'h0003, "R9 restart clears partial");
  endtask

  task automatic t_zero_mask();
    logic seen;
    do_start(16'h0000);
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      send_word(16'h1111 * i, 1'b0);
      seen = seen | out_valid;
    end
    for (int i = 0; i < 5; i++) begin @(negedge clk); seen = seen | out_valid; end
    chk("R10 no output", seen, 1'b0);
    chk("R10 still accepting", in_ready, 1'b1);
  endtask

  initial begin
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_time_order();
    t_all_channels();
    t_sparse();
    t_backpressure();
    t_odd();
    t_mask_latch();
    t_zero_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule